// File: doc/BRIEF.md
# Lockable Software-Loaded Translation Buffer

This block is a fully associative address translation cache of up to 32 entries whose contents are managed entirely by software. Every entry has a match half and a data half. The match half holds a virtual tag, a preserved flag, a valid flag and a page-size code. The data half holds a physical page number and three page attributes. Software writes through a small register-style port. It stages a match word and a data word, chooses or reads the replacement index, and issues one of three commands: load, flush-all-unpreserved, or flush-by-tag.

A combinational lookup port takes a 32-bit virtual address. It reports a hit, reports a multi-hit fault when more than one valid entry matches, and returns the translated physical address. A lock base keeps the lowest entries out of round-robin replacement, which leaves them resident for critical mappings. The preserved flag shields an entry from the flush-all command but not from a flush by tag.

Top module: `tlb_lockable`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses with `lk_hit`=0 and `lk_pa`=0. The replacement index and the lock base both read 0.
- R2: Writing a word with bit 0 set to selector 3 (load) copies the staged match and data words into the entry at the replacement index. The index then advances by one.
- R3: When a load happens at the last index (ENTRIES-1), the replacement index wraps to the lock base instead of 0. Entries below the base are therefore never replaced by successive loads.
- R4: A write to selector 2 (lock) sets the replacement index from bits [4:0] and the lock base from bits [12:8]. Reading selector 2 returns the same layout.
- R5: The page-size code selects the bits used for the tag compare and the page-number substitution: 2 = 4 KB uses VA[31:12], 1 = 64 KB uses VA[31:16], 0 = 1 MB uses VA[31:20], 3 = 16 MB uses VA[31:24]. The physical address is `{ppn & m, va & ~m}` over bits 31:12, and VA[11:0] passes through unchanged.
- R6: Writing bit 0 to selector 4 (global flush) clears the valid flag of every entry whose preserved flag is 0. Preserved entries keep translating.
- R7: Writing bit 0 to selector 5 (targeted flush) clears every valid entry whose tag matches the staged tag under that entry's page-size mask, even when the entry is preserved. Entries that do not match are unaffected.
- R8: A lookup matching two or more valid entries raises `lk_multi` together with `lk_hit`. The address is then taken from the lowest-numbered matching entry.
- R9: Reading selectors 3, 4 and 5 (the commands) always returns 0.
- R10: Selectors 6 and 7 read back the match and data words of the entry at the current replacement index.
- R11: The match word holds the tag in [31:12], the preserved flag at bit 3, the valid flag at bit 2 and the size in [1:0]. The data word holds the page number in [31:12], the endianness bit at 9, the element size in [8:7] and the mixed bit at 6. Unused bits read 0, and selectors 0 and 1 read back the staged words in this layout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register selector for reads |
| rd_data | output | 32 | Combinational read data |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | At least one valid entry matches |
| lk_multi | output | 1 | More than one valid entry matches |
| lk_pa | output | 32 | Translated physical address (0 on miss) |

## Verification
The assertions check on every cycle the rules that can be seen one entry or one step at a time. Those rules are: the index steps after a load and wraps to the base at the last entry, a load writes the staged word into the selected slot, each flush clears or spares entries according to the preserved flag and the tag match, a multi-hit always comes with a hit, and command selectors read zero. Only the bench's scenarios can show the end-to-end results. These include the physical address produced for each of the four page sizes, the lowest-index choice under a multi-hit, the fact that entries below the lock base survive a series of loads that wraps, and the exact bit layout of the staged and read-back words.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        PG_1M  = 2'd0,
        PG_64K = 2'd1,
        PG_4K  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic [19:0] tag;
        logic        prot;
        logic        valid;
        pg_size_e    size;
    } cam_t;

    typedef struct packed {
        logic [19:0] ppn;
        logic        big_end;
        logic [1:0]  esize;
        logic        mixed;
    } ram_t;

    typedef enum logic [2:0] {
        SEL_CAM    = 3'd0,
        SEL_RAM    = 3'd1,
        SEL_LOCK   = 3'd2,
        SEL_LOAD   = 3'd3,
        SEL_GFLUSH = 3'd4,
        SEL_EFLUSH = 3'd5,
        SEL_RDCAM  = 3'd6,
        SEL_RDRAM  = 3'd7
    } reg_sel_e;

    localparam int LOCK_BASE_LSB = 8;

    // Bits of the 20-bit page number that take part in compare/substitution
    function automatic logic [19:0] page_mask(input pg_size_e sz);
        case (sz)
            PG_4K:   page_mask = 20'hFFFFF;
            PG_64K:  page_mask = 20'hFFFF0;
            PG_1M:   page_mask = 20'hFFF00;
            default: page_mask = 20'hFF000;
        endcase
    endfunction

    function automatic logic [31:0] cam_pack(input cam_t c);
        cam_pack = {c.tag, 8'd0, c.prot, c.valid, c.size};
    endfunction

    function automatic cam_t cam_unpack(input logic [31:0] w);
        cam_t c;
        c.tag   = w[31:12];
        c.prot  = w[3];
        c.valid = w[2];
        c.size  = pg_size_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic [31:0] ram_pack(input ram_t r);
        ram_pack = {r.ppn, 2'd0, r.big_end, r.esize, r.mixed, 6'd0};
    endfunction

    function automatic ram_t ram_unpack(input logic [31:0] w);
        ram_t r;
        r.ppn     = w[31:12];
        r.big_end = w[9];
        r.esize   = w[8:7];
        r.mixed   = w[6];
        return r;
    endfunction

endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
    import tlb_pkg::*;
(
    input  cam_t        ent,
    input  logic [19:0] lk_tag,
    input  logic [19:0] fl_tag,
    output logic        lk_match,
    output logic        fl_match
);
    logic [19:0] mask;

    always_comb begin
        mask     = page_mask(ent.size);
        lk_match = ent.valid && (((ent.tag ^ lk_tag) & mask) == 20'd0);
        fl_match = ent.valid && (((ent.tag ^ fl_tag) & mask) == 20'd0);
    end
endmodule

// File: rtl/tlb_hit_sel.sv
module tlb_hit_sel #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] match,
    output logic               hit,
    output logic               multi,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
        hit   = |match;
        multi = $countones(match) > 1;
    end

    AST_MULTI_HAS_HIT: assert property (@(posedge clk) disable iff (rst)
        multi |-> hit); // R8
    AST_IDX_IS_MATCH: assert property (@(posedge clk) disable iff (rst)
        hit |-> match[idx]); // R8
endmodule

// File: rtl/tlb_victim_ctl.sv
module tlb_victim_ctl #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_victim,
    input  logic [IDX_W-1:0] set_base,
    input  logic             step,
    output logic [IDX_W-1:0] victim,
    output logic [IDX_W-1:0] base
);
    always_ff @(posedge clk) begin
        if (rst) begin
            victim <= '0;
            base   <= '0;
        end else if (set_en) begin
            victim <= set_victim;
            base   <= set_base;
        end else if (step) begin
            victim <= (victim == LAST) ? base : victim + 1'b1;
        end
    end

    AST_VICTIM_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !set_en && victim != LAST) |=> victim == $past(victim) + 1'b1); // R2
    AST_VICTIM_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !set_en && victim == LAST) |=> victim == $past(base)); // R3
    AST_VICTIM_SET: assert property (@(posedge clk) disable iff (rst)
        set_en |=> (victim == $past(set_victim) && base == $past(set_base))); // R4
endmodule

// File: rtl/tlb_lockable.sv
module tlb_lockable
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_sel,
    output logic [31:0] rd_data,
    input  logic [31:0] lk_va,
    output logic        lk_hit,
    output logic        lk_multi,
    output logic [31:0] lk_pa
);
    cam_t cam_q [ENTRIES];
    ram_t ram_q [ENTRIES];
    cam_t stg_cam;
    ram_t stg_ram;

    logic [IDX_W-1:0]   victim, base, hit_idx;
    logic [ENTRIES-1:0] lk_match, fl_match;
    logic               load_cmd, gflush_cmd, eflush_cmd, lock_wr;
    reg_sel_e           wsel, rsel;

    assign wsel       = reg_sel_e'(wr_sel);
    assign rsel       = reg_sel_e'(rd_sel);
    assign lock_wr    = wr_en && wsel == SEL_LOCK;
    assign load_cmd   = wr_en && wsel == SEL_LOAD   && wr_data[0];
    assign gflush_cmd = wr_en && wsel == SEL_GFLUSH && wr_data[0];
    assign eflush_cmd = wr_en && wsel == SEL_EFLUSH && wr_data[0];

    tlb_victim_ctl #(.ENTRIES(ENTRIES)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .set_en     (lock_wr),
        .set_victim (wr_data[IDX_W-1:0]),
        .set_base   (wr_data[LOCK_BASE_LSB +: IDX_W]),
        .step       (load_cmd),
        .victim     (victim),
        .base       (base)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlb_entry_cmp u_cmp (
            .ent      (cam_q[g]),
            .lk_tag   (lk_va[31:12]),
            .fl_tag   (stg_cam.tag),
            .lk_match (lk_match[g]),
            .fl_match (fl_match[g])
        );

        AST_GFLUSH_KEEP: assert property (@(posedge clk) disable iff (rst)
            (gflush_cmd && cam_q[g].prot) |=> cam_q[g].valid == $past(cam_q[g].valid)); // R6
        AST_GFLUSH_DROP: assert property (@(posedge clk) disable iff (rst)
            (gflush_cmd && !cam_q[g].prot) |=> !cam_q[g].valid); // R6
        AST_EFLUSH_DROP: assert property (@(posedge clk) disable iff (rst)
            (eflush_cmd && fl_match[g]) |=> !cam_q[g].valid); // R7
        AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (rst)
            (load_cmd && victim == IDX_W'(g)) |=> cam_q[g] == $past(stg_cam)); // R2
    end

    tlb_hit_sel #(.ENTRIES(ENTRIES)) u_sel (
        .clk   (clk),
        .rst   (rst),
        .match (lk_match),
        .hit   (lk_hit),
        .multi (lk_multi),
        .idx   (hit_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_cam <= '0;
            stg_ram <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                cam_q[i] <= '0;
                ram_q[i] <= '0;
            end
        end else if (wr_en) begin
            case (wsel)
                SEL_CAM: stg_cam <= cam_unpack(wr_data);
                SEL_RAM: stg_ram <= ram_unpack(wr_data);
                SEL_LOAD: if (load_cmd) begin
                    cam_q[victim] <= stg_cam;
                    ram_q[victim] <= stg_ram;
                end
                SEL_GFLUSH: if (gflush_cmd) begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (!cam_q[i].prot) cam_q[i].valid <= 1'b0;
                end
                SEL_EFLUSH: if (eflush_cmd) begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (fl_match[i]) cam_q[i].valid <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Physical address composition from the selected entry
    logic [19:0] pmask;
    always_comb begin
        pmask = page_mask(cam_q[hit_idx].size);
        lk_pa = lk_hit ? {(ram_q[hit_idx].ppn & pmask) | (lk_va[31:12] & ~pmask), lk_va[11:0]}
                       : 32'd0;
    end

    always_comb begin
        rd_data = 32'd0;
        case (rsel)
            SEL_CAM:   rd_data = cam_pack(stg_cam);
            SEL_RAM:   rd_data = ram_pack(stg_ram);
            SEL_LOCK: begin
                rd_data[IDX_W-1:0]               = victim;
                rd_data[LOCK_BASE_LSB +: IDX_W]  = base;
            end
            SEL_RDCAM: rd_data = cam_pack(cam_q[victim]);
            SEL_RDRAM: rd_data = ram_pack(ram_q[victim]);
            default:   rd_data = 32'd0;
        endcase
    end

    AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsel == SEL_LOAD || rsel == SEL_GFLUSH || rsel == SEL_EFLUSH) |-> rd_data == 32'd0); // R9
    AST_HIT_ENTRY_VALID: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> cam_q[hit_idx].valid); // R5
endmodule

// File: tb/tlb_lockable_bench.sv
`timescale 1ns/1ps
module tlb_lockable_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [31:0] wr_data;
    logic [2:0]  rd_sel;
    logic [31:0] rd_data;
    logic [31:0] lk_va;
    logic        lk_hit, lk_multi;
    logic [31:0] lk_pa;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tlb_lockable u_tlb_lockable (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .lk_va(lk_va),
        .lk_hit(lk_hit), .lk_multi(lk_multi), .lk_pa(lk_pa)
    );

    typedef struct packed {
        logic [31:0] va;
        logic        hit;
        logic [31:0] pa;
    } vec_t;

    // R5: one lookup per page size, plus misses just outside each page
    localparam vec_t VECS [6] = '{
        '{va: 32'h12345678, hit: 1'b1, pa: 32'hABCDE678},
        '{va: 32'h12346678, hit: 1'b0, pa: 32'h00000000},
        '{va: 32'h2222F123, hit: 1'b1, pa: 32'h5555F123},
        '{va: 32'h33398765, hit: 1'b1, pa: 32'h77798765},
        '{va: 32'h44ABCDEF, hit: 1'b1, pa: 32'h99ABCDEF},
        '{va: 32'h45000000, hit: 1'b0, pa: 32'h00000000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic look(input logic [31:0] va);
        lk_va = va;
        #1;
    endtask

    task automatic load_entry(input logic [31:0] cw, input logic [31:0] rw);
        wr(3'd0, cw);
        wr(3'd1, rw);
        wr(3'd3, 32'd1);
    endtask

    initial begin
        logic [31:0] d;
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0; lk_va = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        look(32'h12345678);
        chk("R1 hit after reset", {31'd0, lk_hit}, 32'd0);
        chk("R1 pa after reset", lk_pa, 32'd0);
        rd(3'd2, d);
        chk("R1 lock after reset", d, 32'd0);

        load_entry(32'h12345006, 32'hABCDE340); // 4 KB
        load_entry(32'h2222000D, 32'h55550000); // 64 KB, preserved
        load_entry(32'h33300004, 32'h77700000); // 1 MB
        load_entry(32'h4400000F, 32'h99000000); // 16 MB, preserved

        // R2 index advanced by four loads
        rd(3'd2, d);
        chk("R2 victim after loads", d, 32'h4);

        for (int i = 0; i < 6; i++) begin
            look(VECS[i].va);
            chk("R5 table hit", {31'd0, lk_hit}, {31'd0, VECS[i].hit});
            chk("R5 table pa", lk_pa, VECS[i].pa);
        end

        // R4 / R10 point index at entry 0 and read it back
        wr(3'd2, 32'h0);
        rd(3'd2, d);
        chk("R4 lock readback", d, 32'h0);
        rd(3'd6, d);
        chk("R10 read cam", d, 32'h12345006);
        rd(3'd7, d);
        chk("R10 read ram", d, 32'hABCDE340);

        // R9 command selectors read zero
        rd(3'd3, d); chk("R9 load reads 0", d, 32'd0);
        rd(3'd4, d); chk("R9 gflush reads 0", d, 32'd0);
        rd(3'd5, d); chk("R9 eflush reads 0", d, 32'd0);

        // R11 staged word layout
        wr(3'd0, 32'hFFFFFFFF);
        rd(3'd0, d); chk("R11 staged cam layout", d, 32'hFFFFF00F);
        wr(3'd1, 32'hFFFFFFFF);
        rd(3'd1, d); chk("R11 staged ram layout", d, 32'hFFFFF3C0);

        // R8 duplicate at index 4
        wr(3'd2, 32'h4);
        load_entry(32'h12345006, 32'h11111000);
        look(32'h12345678);
        chk("R8 multi", {30'd0, lk_hit, lk_multi}, 32'h3);
        chk("R8 lowest index pa", lk_pa, 32'hABCDE678);

        // R7 targeted flush removes both duplicates, and a preserved entry
        wr(3'd0, 32'h12345000);
        wr(3'd5, 32'd1);
        look(32'h12345678);
        chk("R7 tag flush", {31'd0, lk_hit}, 32'd0);
        wr(3'd0, 32'h22220000);
        wr(3'd5, 32'd1);
        look(32'h2222F123);
        chk("R7 flush preserved", {31'd0, lk_hit}, 32'd0);
        look(32'h33398765);
        chk("R7 other kept", lk_pa, 32'h77798765);

        // R6 global flush
        wr(3'd4, 32'd1);
        look(32'h33398765);
        chk("R6 unpreserved gone", {31'd0, lk_hit}, 32'd0);
        look(32'h44ABCDEF);
        chk("R6 preserved kept", lk_pa, 32'h99ABCDEF);

        // R3 wrap to lock base
        wr(3'd2, 32'h1E1F);
        load_entry(32'h60000006, 32'h0A000000);
        rd(3'd2, d); chk("R3 wrap to base", d, 32'h1E1E);
        load_entry(32'h61000006, 32'h0A000000);
        rd(3'd2, d); chk("R3 step after wrap", d, 32'h1E1F);
        load_entry(32'h62000006, 32'h0A000000);
        rd(3'd2, d); chk("R3 second wrap", d, 32'h1E1E);
        look(32'h60000123);
        chk("R3 slot 31 replaced", {31'd0, lk_hit}, 32'd0);
        look(32'h62000ABC);
        chk("R3 new entry", lk_pa, 32'h0A000ABC);
        look(32'h61000ABC);
        chk("R3 slot 30 kept", lk_pa, 32'h0A000ABC);
        look(32'h44ABCDEF);
        chk("R3 locked entry kept", lk_pa, 32'h99ABCDEF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule